// File: doc/BRIEF.md
# Flash Instruction Line Cache with Next-Line Prefetch

This block sits between the instruction fetch port of a processor and a slow flash array that delivers one 256-bit line (four 64-bit words) per read. Each read takes a programmable number of wait cycles. Before the cache is consulted, every fetch is compared against two line registers: the line most recently read on demand (the current line) and a speculatively read next line (the prefetch line). Behind those sits a fully associative store of `LINES` lines. A fetch that matches any of the three is answered in the same cycle.

A fetch that matches none of the three stalls the requester while the block reads the line from flash. It then loads the line into the current line register and, when caching is enabled, writes it into the store. Once every store line is valid, the victim is the least recently used line, tracked with one age per line.

When the requester consumes the last word of the current line, the block starts reading the following line on its own. A flush input empties the store, and the enable input lets fetches bypass the store without losing what it holds.

Top module: `flash_icache`

## Requirements
- R1: After reset no flash read is active (`fl_rd` low), and the first fetch is treated as a miss.
- R2: A fetch that misses the current line, the prefetch line and the store, with the flash idle, drives `fl_rd` for exactly `wait_cyc`+1 cycles with `fl_line` = `req_addr[ADDR_W-1:2]`. `req_ready` stays low for `wait_cyc`+2 cycles and then rises. The returned word is word `req_addr[1:0]` of the line, where word w sits at line bits [64w+63:64w].
- R3: Fetches to any word of the current line get `req_ready` in the cycle they are presented and start no flash read.
- R4: With `cache_en` high, a fetch to a line held in the store is answered in the same cycle with no flash read, even after the current line has moved on.
- R5: When all store lines are valid, a fill overwrites the least recently used line, and both a store hit and a fill make the touched line the most recently used.
- R6: Accepting a fetch of word 3 of the current line, with the flash idle and the next line not already in the prefetch register, starts a read of line tag+1. A later fetch to that line is answered in the same cycle without another read.
- R7: While `cache_en` is low the store is neither searched nor filled. Lines it held before are hit again once `cache_en` returns high.
- R8: A one-cycle `cache_flush` invalidates every store line but leaves the current and prefetch lines usable.
- R9: At most one flash read is active at a time, and `fl_line` is stable while it is. A missing fetch that arrives during a prefetch waits for that read to end and then starts its own, so `req_ready` rises 2·`wait_cyc`+2 cycles after the fetch appears when the prefetch began one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Store lookup and fill enable |
| cache_flush | input | 1 | Synchronous invalidate of all store lines |
| wait_cyc | input | WS_W | Flash wait cycles per line read |
| req_valid | input | 1 | Fetch request, held until accepted |
| req_addr | input | ADDR_W | Fetch address in 64-bit words |
| req_ready | output | 1 | Fetch accepted and data valid this cycle |
| rsp_data | output | WORD_W | Fetched word |
| fl_rd | output | 1 | Flash line read in progress |
| fl_line | output | ADDR_W-log2(WORDS) | Line address being read |
| fl_rdata | input | WORD_W*WORDS | Flash line data, sampled on the last read cycle |

## Verification
A bad valid bit or tag in any of the three line holders shows up at the ports in the very cycle of the next fetch to that line. It appears either as a `req_ready` that rises without a flash read or as an unexpected `wait_cyc`+2 stall. A wrong age ordering stays hidden until the store is full and a fill evicts the wrong victim. It appears one fetch later, as a miss on a line that should have survived or a hit on one that should not. A broken wait counter or a lost prefetch changes stall lengths by whole cycles, so the bench times each fetch exactly.

// File: rtl/fic_pkg.sv
package fic_pkg;
  // Kind of flash line read in flight
  typedef enum logic [1:0] {
    FL_IDLE   = 2'd0,
    FL_DEMAND = 2'd1,
    FL_PREF   = 2'd2
  } fl_kind_e;
endpackage

// File: rtl/fic_flash_seq.sv
module fic_flash_seq
  import fic_pkg::*;
#(
  parameter int TAG_W = 14,
  parameter int WS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WS_W-1:0]  wait_cyc,
  input  logic             start_dem,
  input  logic [TAG_W-1:0] dem_tag,
  input  logic             start_pref,
  input  logic [TAG_W-1:0] pref_tag,
  output logic             busy,
  output logic [TAG_W-1:0] cur_tag,
  output logic             done_dem,
  output logic             done_pref
);
  fl_kind_e         st_q, st_d;
  logic [WS_W-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             last;

  assign busy      = (st_q != FL_IDLE);
  assign last      = busy && (cnt_q == '0);
  assign done_dem  = last && (st_q == FL_DEMAND);
  assign done_pref = last && (st_q == FL_PREF);
  assign cur_tag   = tag_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tag_d = tag_q;
    if (st_q == FL_IDLE) begin
      if (start_dem) begin
        st_d  = FL_DEMAND;
        cnt_d = wait_cyc;
        tag_d = dem_tag;
      end else if (start_pref) begin
        st_d  = FL_PREF;
        cnt_d = wait_cyc;
        tag_d = pref_tag;
      end
    end else if (cnt_q == '0) begin
      st_d = FL_IDLE;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FL_IDLE;
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tag_q <= tag_d;
    end
  end
endmodule

// File: rtl/fic_lru_order.sv
module fic_lru_order #(
  parameter int LINES = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch,
  input  logic [$clog2(LINES)-1:0] touch_idx,
  output logic [$clog2(LINES)-1:0] victim_idx
);
  localparam int IDX_W = $clog2(LINES);

  // Ages form a permutation of 0..LINES-1; 0 is most recent
  logic [IDX_W-1:0] age_q [LINES];
  logic [IDX_W-1:0] age_d [LINES];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age_q[touch_idx];

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      age_d[i] = age_q[i];
      if (touch) begin
        if (touch_idx == IDX_W'(i))
          age_d[i] = '0;
        else if (age_q[i] < ref_age)
          age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (age_q[i] == IDX_W'(LINES - 1)) victim_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= age_d[i];
    end
  end
endmodule

// File: rtl/fic_cache_array.sv
module fic_cache_array #(
  parameter int TAG_W  = 14,
  parameter int LINE_W = 256,
  parameter int LINES  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TAG_W-1:0]         look_tag,
  output logic                     hit,
  output logic [$clog2(LINES)-1:0] hit_idx,
  output logic [LINE_W-1:0]        hit_line,
  output logic                     any_free,
  output logic [$clog2(LINES)-1:0] free_idx,
  input  logic                     flush,
  input  logic                     fill_en,
  input  logic [$clog2(LINES)-1:0] fill_idx,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic [LINE_W-1:0]        fill_line
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];
  logic [LINES-1:0]  match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == look_tag);
  end

  assign hit      = |match;
  assign any_free = ~&vld_q;
  assign hit_line = data_q[hit_idx];

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i])  hit_idx  = IDX_W'(i);
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (flush)
      vld_d = '0;
    else if (fill_en)
      vld_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Tag and data storage carry no reset; valid bits qualify them
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_line;
    end
  end
endmodule

// File: rtl/flash_icache.sv
module flash_icache #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 64,
  parameter int WORDS  = 4,
  parameter int LINES  = 32,
  parameter int WS_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cache_en,
  input  logic                             cache_flush,
  input  logic [WS_W-1:0]                  wait_cyc,
  input  logic                             req_valid,
  input  logic [ADDR_W-1:0]                req_addr,
  output logic                             req_ready,
  output logic [WORD_W-1:0]                rsp_data,
  output logic                             fl_rd,
  output logic [ADDR_W-$clog2(WORDS)-1:0]  fl_line,
  input  logic [WORD_W*WORDS-1:0]          fl_rdata
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LINE_W = WORD_W * WORDS;
  localparam int IDX_W  = $clog2(LINES);

  // Request decode
  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  assign req_tag = req_addr[ADDR_W-1:OFF_W];
  assign req_off = req_addr[OFF_W-1:0];

  // Line registers
  logic              cur_vld_q, cur_vld_d;
  logic [TAG_W-1:0]  cur_tag_q, cur_tag_d;
  logic [LINE_W-1:0] cur_line_q, cur_line_d;
  logic              cur_ld;
  logic              pf_vld_q, pf_vld_d;
  logic [TAG_W-1:0]  pf_tag_q;
  logic [LINE_W-1:0] pf_line_q;
  logic              fill_ok_q, fill_ok_d;

  // Store interface
  logic              c_hit, c_any_free;
  logic [IDX_W-1:0]  c_hit_idx, c_free_idx, lru_victim, fill_idx;
  logic [LINE_W-1:0] c_line;
  logic              fill_en, touch;
  logic [IDX_W-1:0]  touch_idx;

  // Flash sequencer interface
  logic              fl_busy, done_dem, done_pref;
  logic              start_dem, start_pref;
  logic [TAG_W-1:0]  seq_tag, next_tag;

  // Hit detection, current line first, then prefetch line, then store
  logic hit_cur, hit_pf, hit_c, any_hit, take_pf, take_c;
  assign hit_cur = cur_vld_q && (cur_tag_q == req_tag);
  assign hit_pf  = pf_vld_q && (pf_tag_q == req_tag);
  assign hit_c   = cache_en && c_hit;
  assign any_hit = hit_cur || hit_pf || hit_c;
  assign req_ready = req_valid && any_hit;
  assign take_pf = req_ready && !hit_cur && hit_pf;
  assign take_c  = req_ready && !hit_cur && !hit_pf;

  logic [LINE_W-1:0] sel_line;
  logic [WORD_W-1:0] sel_words [WORDS];
  always_comb begin
    if (hit_cur)     sel_line = cur_line_q;
    else if (hit_pf) sel_line = pf_line_q;
    else             sel_line = c_line;
  end
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign sel_words[w] = sel_line[w*WORD_W +: WORD_W];
  end
  assign rsp_data = sel_words[req_off];

  // Flash read launch
  assign next_tag   = cur_tag_q + 1'b1;
  assign start_dem  = req_valid && !any_hit && !fl_busy;
  assign start_pref = req_ready && hit_cur && (req_off == {OFF_W{1'b1}}) &&
                      !fl_busy && !(pf_vld_q && (pf_tag_q == next_tag));

  fic_flash_seq #(.TAG_W(TAG_W), .WS_W(WS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_cyc   (wait_cyc),
    .start_dem  (start_dem),
    .dem_tag    (req_tag),
    .start_pref (start_pref),
    .pref_tag   (next_tag),
    .busy       (fl_busy),
    .cur_tag    (seq_tag),
    .done_dem   (done_dem),
    .done_pref  (done_pref)
  );
  assign fl_rd   = fl_busy;
  assign fl_line = seq_tag;

  // Store fill and recency
  assign fill_en   = done_dem && fill_ok_q && cache_en;
  assign fill_idx  = c_any_free ? c_free_idx : lru_victim;
  assign touch     = fill_en || (take_c && !done_dem);
  assign touch_idx = fill_en ? fill_idx : c_hit_idx;

  fic_cache_array #(.TAG_W(TAG_W), .LINE_W(LINE_W), .LINES(LINES)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_tag  (req_tag),
    .hit       (c_hit),
    .hit_idx   (c_hit_idx),
    .hit_line  (c_line),
    .any_free  (c_any_free),
    .free_idx  (c_free_idx),
    .flush     (cache_flush),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_tag  (seq_tag),
    .fill_line (fl_rdata)
  );

  fic_lru_order #(.LINES(LINES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (touch),
    .touch_idx  (touch_idx),
    .victim_idx (lru_victim)
  );

  // Next-state for line registers
  always_comb begin
    cur_vld_d  = cur_vld_q;
    cur_tag_d  = cur_tag_q;
    cur_line_d = cur_line_q;
    cur_ld     = 1'b0;
    if (done_dem) begin
      cur_vld_d  = 1'b1;
      cur_tag_d  = seq_tag;
      cur_line_d = fl_rdata;
      cur_ld     = 1'b1;
    end else if (take_pf) begin
      cur_vld_d  = 1'b1;
      cur_tag_d  = pf_tag_q;
      cur_line_d = pf_line_q;
      cur_ld     = 1'b1;
    end
  end

  always_comb begin
    pf_vld_d = pf_vld_q;
    if (take_pf)   pf_vld_d = 1'b0;
    if (done_pref) pf_vld_d = 1'b1;
  end

  assign fill_ok_d = start_dem ? cache_en : fill_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_vld_q <= 1'b0;
      pf_vld_q  <= 1'b0;
      fill_ok_q <= 1'b0;
    end else begin
      cur_vld_q <= cur_vld_d;
      pf_vld_q  <= pf_vld_d;
      fill_ok_q <= fill_ok_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cur_ld) begin
      cur_tag_q  <= cur_tag_d;
      cur_line_q <= cur_line_d;
    end
    if (done_pref) begin
      pf_tag_q  <= seq_tag;
      pf_line_q <= fl_rdata;
    end
  end
endmodule

// File: rtl/flash_icache_chk.sv
module flash_icache_chk #(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  parameter int WS_W   = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [WS_W-1:0]                 wait_cyc,
  input logic                            req_valid,
  input logic [ADDR_W-1:0]               req_addr,
  input logic                            req_ready,
  input logic                            fl_rd,
  input logic [ADDR_W-$clog2(WORDS)-1:0] fl_line
);
  localparam int OFF_W     = $clog2(WORDS);
  localparam int MAX_STALL = 2 * ((1 << WS_W) + 1) + 2;

  logic            rd_prev;
  logic [WS_W-1:0] ws_prev, ws_lock;
  logic [WS_W:0]   rd_cnt;
  logic [7:0]      stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev   <= 1'b0;
      ws_prev   <= '0;
      ws_lock   <= '0;
      rd_cnt    <= '0;
      stall_cnt <= '0;
    end else begin
      rd_prev <= fl_rd;
      ws_prev <= wait_cyc;
      if (fl_rd && !rd_prev) ws_lock <= ws_prev;
      rd_cnt    <= fl_rd ? rd_cnt + 1'b1 : '0;
      stall_cnt <= (req_valid && !req_ready) ? stall_cnt + 1'b1 : '0;
    end
  end

  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_rd) |-> (rd_cnt == ({1'b0, ws_lock} + (WS_W+1)'(1)))); // R2

  AST_HIT_NO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && (req_addr[OFF_W-1:0] != {OFF_W{1'b1}})) |=> !$rose(fl_rd)); // R3

  AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && $past(fl_rd)) |-> (fl_line == $past(fl_line))); // R9

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (stall_cnt <= 8'(MAX_STALL))); // R9
endmodule

bind flash_icache flash_icache_chk #(
  .ADDR_W (ADDR_W),
  .WORDS  (WORDS),
  .WS_W   (WS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wait_cyc  (wait_cyc),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_ready (req_ready),
  .fl_rd     (fl_rd),
  .fl_line   (fl_line)
);

// File: tb/tb_flash_icache.sv
module tb_flash_icache;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n, cache_en, cache_flush;
  logic [3:0]   wait_cyc;
  logic         req_valid, req_ready;
  logic [15:0]  req_addr;
  logic [63:0]  rsp_data;
  logic         fl_rd;
  logic [13:0]  fl_line;
  logic [255:0] fl_rdata;

  int n_checks = 0, n_fails = 0, n_reads = 0;
  logic rd_prev;
  bit   done = 0;

  flash_icache dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .cache_flush(cache_flush),
    .wait_cyc(wait_cyc), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_data(rsp_data), .fl_rd(fl_rd),
    .fl_line(fl_line), .fl_rdata(fl_rdata)
  );

  function automatic logic [63:0] exp_word(input logic [15:0] a);
    return {16'hBEEF, a, ~a, a ^ 16'h5A5A};
  endfunction

  function automatic logic [255:0] mk_line(input logic [13:0] t);
    logic [255:0] l;
    for (int w = 0; w < 4; w++) l[w*64 +: 64] = exp_word({t, 2'(w)});
    return l;
  endfunction

  assign fl_rdata = mk_line(fl_line);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev <= 1'b0;
    else begin
      rd_prev <= fl_rd;
      if (fl_rd && !rd_prev) n_reads <= n_reads + 1;
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic fetch(input logic [15:0] a, output int lat, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    lat = 0;
    d   = '0;
    forever begin
      #1;
      if (req_ready) begin
        d = rsp_data;
        break;
      end
      @(negedge clk);
      lat++;
      if (lat > 100) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_fetch(input string rq, input logic [15:0] a,
                              input int exp_lat, input int exp_rd);
    int lat;
    logic [63:0] d;
    int r0;
    r0 = n_reads;
    fetch(a, lat, d);
    check({rq, " latency"}, 64'(lat), 64'(exp_lat));
    check({rq, " data"}, d, exp_word(a));
    check({rq, " flash reads"}, 64'(n_reads - r0), 64'(exp_rd));
  endtask

  task automatic t_reset;
    check("R1 fl_rd after reset", 64'(fl_rd), 64'd0);
    check("R1 no reads after reset", 64'(n_reads), 64'd0);
  endtask

  task automatic t_miss;
    wait_cyc = 4'd3;
    expect_fetch("R1 R2 first miss ws3", 16'h0040, 5, 1);
    wait_cyc = 4'd0;
    expect_fetch("R2 miss ws0", 16'h0104, 2, 1);
  endtask

  task automatic t_cur_line;
    expect_fetch("R3 cur word1", 16'h0105, 0, 0);
    expect_fetch("R3 cur word2", 16'h0106, 0, 0);
    expect_fetch("R3 cur word0", 16'h0104, 0, 0);
  endtask

  task automatic t_cache_hit;
    wait_cyc = 4'd2;
    expect_fetch("R4 store hit", 16'h0041, 0, 0);
  endtask

  task automatic t_enable;
    cache_en = 1'b0;
    expect_fetch("R7 bypass miss", 16'h0040, 4, 1);
    expect_fetch("R7 no fill a", 16'h0300, 4, 1);
    expect_fetch("R7 no fill b", 16'h0400, 4, 1);
    cache_en = 1'b1;
    expect_fetch("R7 contents kept", 16'h0104, 0, 0);
    expect_fetch("R7 disabled line not stored", 16'h0300, 4, 1);
  endtask

  task automatic t_prefetch;
    int r0;
    r0 = n_reads;
    expect_fetch("R6 last word hit", 16'h0303, 0, 0);
    #1;
    check("R6 prefetch active", 64'(fl_rd), 64'd1);
    check("R6 prefetch line", 64'(fl_line), 64'h0C1);
    repeat (6) @(negedge clk);
    check("R6 one prefetch read", 64'(n_reads - r0), 64'd1);
    expect_fetch("R6 prefetched line hit", 16'h0304, 0, 0);
  endtask

  task automatic t_overlap;
    expect_fetch("R6 R9 last word again", 16'h0307, 0, 0);
    expect_fetch("R9 miss behind prefetch", 16'h0500, 6, 2);
    expect_fetch("R9 prefetch kept", 16'h0308, 0, 0);
  endtask

  task automatic t_flush;
    @(negedge clk) cache_flush = 1'b1;
    @(negedge clk) cache_flush = 1'b0;
    expect_fetch("R8 cur survives flush", 16'h0309, 0, 0);
    expect_fetch("R8 store emptied", 16'h0104, 4, 1);
  endtask

  task automatic t_lru;
    wait_cyc = 4'd0;
    @(negedge clk) cache_flush = 1'b1;
    @(negedge clk) cache_flush = 1'b0;
    for (int i = 0; i < 32; i++)
      expect_fetch("R5 fill", 16'((16'h200 + i) << 2), 2, 1);
    expect_fetch("R5 touch oldest", 16'h0800, 0, 0);
    expect_fetch("R5 fill evicts lru", 16'h0880, 2, 1);
    expect_fetch("R5 touched line kept", 16'h0800, 0, 0);
    expect_fetch("R5 touch 202", 16'h0808, 0, 0);
    expect_fetch("R5 201 was victim", 16'h0804, 2, 1);
    expect_fetch("R5 203 was victim", 16'h080C, 2, 1);
    expect_fetch("R5 205 still held", 16'h0814, 0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    cache_en    = 1'b1;
    cache_flush = 1'b0;
    wait_cyc    = 4'd2;
    req_valid   = 1'b0;
    req_addr    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss();
    t_cur_line();
    t_cache_hit();
    t_enable();
    t_prefetch();
    t_overlap();
    t_flush();
    t_lru();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule